// File: doc/BRIEF.md
# Two-Output Level Interrupt Combiner

This block collects 32 level-sensitive interrupt request lines and folds them onto two CPU interrupt pins. Each line passes through a two-flop synchronizer, is qualified by a mask bit, and is then steered to one of the two pins by a per-source steering bit. Each pin has its own pending word. A pin is high whenever its pending word is nonzero, one cycle after that word changes. Mask bit 31 also acts as a master gate: while it is clear, both pending words read zero and both pins stay low.

Software reaches the block through a small register port. The port has a byte address, write data, a write strobe, a read strobe and registered read data. Mask bits are never written directly. A set-port writes ones into the mask, and a separate clear-port removes them. Either port can therefore touch one source without a read-modify-write. A handler reads the pending word for the pin that fired and services the lowest set bit. A pending word that reads zero marks the event as spurious. The port has no back-pressure: every strobe is taken in the cycle it is presented, so there is no valid/ready pair.

Top module: `intc_cascade`

## Requirements
- R1: After reset the mask word, including bit 31, and the steering word are zero, both interrupt pins are low and the read data is zero.
- R2: A write to byte offset 0x34 ORs the write data into the mask word, so data bits of 0 leave their mask bits unchanged. A read of 0x34 returns the mask word.
- R3: A write to byte offset 0x38 clears every mask bit whose data bit is 1. Writing all ones clears the whole mask, including bit 31. A read of 0x38 returns zero.
- R4: The steering word lives at byte offset 0x20 and can be read and written. Steering bit i = 0 routes source i to pin 0, and steering bit i = 1 routes it to pin 1.
- R5: Offset 0x00 reads raw & mask & ~steer and offset 0x04 reads raw & mask & steer, provided mask bit 31 is set.
- R6: While mask bit 31 is clear, both pending words read zero and both pins are low one cycle later.
- R7: Each pin is a register that holds the OR of its pending word as it was in the previous cycle.
- R8: Offset 0x30 reads the request lines as they were two clock edges before the read edge. This is the output of the two-flop synchronizer.
- R9: Writes to 0x00, 0x04, 0x30 and to undefined offsets change nothing. Every undefined offset reads zero.
- R10: A read strobe sampled at an edge loads the addressed value into the read data at that edge. Without a strobe the read data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 32 | Level-sensitive request lines, asynchronous |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 32 | Registered read data |
| cpu_irq0_o | output | 1 | Interrupt pin 0 |
| cpu_irq1_o | output | 1 | Interrupt pin 1 |

## Verification
The bench drives a request line and samples pin 0 on the second and third edges after the change. A missing synchronizer stage, or an unregistered pin, shows up as a pin that rises too early. Clearing only the master bit must silence both pins while every other mask bit survives; a design that kept bit 31 out of the gate would leave the pins asserted. Writing zeros to the set-port, and writing to read-only offsets, must leave the mask and raw words unchanged. A design that wrote the mask directly, or decoded addresses loosely, would corrupt them. Moving a source between pins checks that it never shows up in both pending words at once.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC   = 32;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_PEND0 = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PEND1 = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_STEER = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_SET   = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h38;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      sync_o   <= '0;
    end else begin
      stage1_q <= async_i;
      sync_o   <= stage1_q;
    end
  end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int W  = NSRC,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [W-1:0]  raw_i,
  input  logic [W-1:0]  pend0_i,
  input  logic [W-1:0]  pend1_i,
  output logic [W-1:0]  mask_o,
  output logic [W-1:0]  steer_o,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o  <= '0;
      steer_o <= '0;
    end else if (wr_i) begin
      if (addr_i == OFS_SET[AW-1:0]) mask_o  <= mask_o | wdata_i;
      if (addr_i == OFS_CLR[AW-1:0]) mask_o  <= mask_o & ~wdata_i;
      if (addr_i == OFS_STEER[AW-1:0]) steer_o <= wdata_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == OFS_PEND0[AW-1:0]) rd_mux = pend0_i;
    if (addr_i == OFS_PEND1[AW-1:0]) rd_mux = pend1_i;
    if (addr_i == OFS_STEER[AW-1:0]) rd_mux = steer_o;
    if (addr_i == OFS_RAW[AW-1:0])   rd_mux = raw_i;
    if (addr_i == OFS_SET[AW-1:0])   rd_mux = mask_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/intc_route.sv
module intc_route #(
  parameter int W    = 32,
  parameter int NOUT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    raw_i,
  input  logic [W-1:0]    mask_i,
  input  logic [W-1:0]    steer_i,
  output logic [W-1:0]    pend_o [NOUT],
  output logic [NOUT-1:0] irq_o
);
  localparam int GBIT = W - 1;

  logic [W-1:0] live;
  assign live = mask_i[GBIT] ? (raw_i & mask_i) : '0;

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    logic [W-1:0] sel;
    assign sel       = (o == 0) ? ~steer_i : steer_i;
    assign pend_o[o] = live & sel;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o[o] <= 1'b0;
      else        irq_o[o] <= |pend_o[o];
    end
  end
endmodule

// File: rtl/intc_cascade.sv
module intc_cascade
  import intc_pkg::*;
#(
  parameter int W  = NSRC,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  irq_src_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [W-1:0]  reg_wdata_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  output logic [W-1:0]  reg_rdata_o,
  output logic          cpu_irq0_o,
  output logic          cpu_irq1_o
);
  logic [W-1:0] raw_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] steer_q;
  logic [W-1:0] pend [2];
  logic [W-1:0] pend0;
  logic [W-1:0] pend1;
  logic [1:0]   irq_q;

  intc_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(irq_src_i), .sync_o(raw_q)
  );

  intc_route #(.W(W), .NOUT(2)) u_route (
    .clk(clk), .rst_n(rst_n), .raw_i(raw_q), .mask_i(mask_q),
    .steer_i(steer_q), .pend_o(pend), .irq_o(irq_q)
  );

  assign pend0 = pend[0];
  assign pend1 = pend[1];

  intc_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .raw_i(raw_q), .pend0_i(pend0),
    .pend1_i(pend1), .mask_o(mask_q), .steer_o(steer_q), .rdata_o(reg_rdata_o)
  );

  assign cpu_irq0_o = irq_q[0];
  assign cpu_irq1_o = irq_q[1];
endmodule

// File: rtl/intc_cascade_chk.sv
module intc_cascade_chk
  import intc_pkg::*;
#(
  parameter int W  = NSRC,
  parameter int AW = ADDR_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  wdata,
  input logic          wr,
  input logic [W-1:0]  mask,
  input logic [W-1:0]  steer,
  input logic [W-1:0]  pend0,
  input logic [W-1:0]  pend1,
  input logic          irq0,
  input logic          irq1
);
  // R2: set-port makes every written one visible in the mask
  p_set_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_SET[AW-1:0]) |=> ((mask & $past(wdata)) == $past(wdata)));

  // R3: clear-port removes every written one
  p_clr_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_CLR[AW-1:0]) |=> ((mask & $past(wdata)) == '0));

  // R2: without a set or clear write the mask holds
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (addr == OFS_SET[AW-1:0] || addr == OFS_CLR[AW-1:0])) |=> $stable(mask));

  // R4: steering word changes only through its own offset
  p_steer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == OFS_STEER[AW-1:0]) |=> $stable(steer));

  // R5: a source never pends on both pins
  p_disjoint_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend0 & pend1) == '0);

  // R6: master bit clear silences both pins next cycle
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask[W-1] |=> (!irq0 && !irq1));

  // R7: pins follow their pending words by one cycle
  p_pin0_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend0 != '0) |=> irq0);
  p_pin1_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend1 == '0) |=> !irq1);
endmodule

bind intc_cascade intc_cascade_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(reg_addr_i), .wdata(reg_wdata_i),
  .wr(reg_wr_i), .mask(mask_q), .steer(steer_q), .pend0(pend0),
  .pend1(pend1), .irq0(cpu_irq0_o), .irq1(cpu_irq1_o)
);

// File: tb/tb_intc_cascade.sv
`timescale 1ns/1ps
module tb_intc_cascade;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic        irq0, irq1;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  intc_cascade dut (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_rdata_o(rdata), .cpu_irq0_o(irq0), .cpu_irq1_o(irq1)
  );

  // behavioural reference
  logic [31:0] m_s1, m_raw, m_mask, m_steer, m_rdata;
  logic        m_o0, m_o1;

  function automatic logic [31:0] m_pend(input logic [31:0] raw, mask, steer, input bit hi);
    if (!mask[31]) return 32'h0;
    return hi ? (raw & mask & steer) : (raw & mask & ~steer);
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_pend(m_raw, m_mask, m_steer, 1'b0);
      8'h04: return m_pend(m_raw, m_mask, m_steer, 1'b1);
      8'h20: return m_steer;
      8'h30: return m_raw;
      8'h34: return m_mask;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_raw = '0; m_mask = '0; m_steer = '0;
      m_rdata = '0; m_o0 = 0; m_o1 = 0;
    end else begin
      logic [31:0] nrd, nmask, nsteer;
      logic n0, n1;
      n0 = |m_pend(m_raw, m_mask, m_steer, 1'b0);
      n1 = |m_pend(m_raw, m_mask, m_steer, 1'b1);
      nrd = rd ? m_read(addr) : m_rdata;
      nmask = m_mask; nsteer = m_steer;
      if (wr && addr == 8'h34) nmask = m_mask | wdata;
      if (wr && addr == 8'h38) nmask = m_mask & ~wdata;
      if (wr && addr == 8'h20) nsteer = wdata;
      m_raw = m_s1; m_s1 = irq_src;
      m_mask = nmask; m_steer = nsteer; m_rdata = nrd;
      m_o0 = n0; m_o1 = n1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      check("R7 pin0 vs model", {31'b0, irq0}, {31'b0, m_o0});
      check("R7 pin1 vs model", {31'b0, irq1}, {31'b0, m_o1});
      check("R10 rdata vs model", rdata, m_rdata);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check(tag, rdata, exp);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 reset rdata", rdata, 32'h0);
    check("R1 reset pins", {30'b0, irq1, irq0}, 32'h0);
    rd_check(8'h34, 32'h0, "R1 reset mask");
    rd_check(8'h20, 32'h0, "R1 reset steer");

    wr_reg(8'h34, 32'h8000000F);
    wr_reg(8'h34, 32'h00000010);
    rd_check(8'h34, 32'h8000001F, "R2 set accumulates");
    wr_reg(8'h34, 32'h0);
    rd_check(8'h34, 32'h8000001F, "R2 zeros keep mask");

    irq_src = 32'h0000_0006;
    idle(4);
    rd_check(8'h30, 32'h6, "R8 raw lines");
    rd_check(8'h00, 32'h6, "R5 pending pin0");
    check("R7 pin0 high", {31'b0, irq0}, 32'h1);

    wr_reg(8'h20, 32'h4);
    idle(1);
    rd_check(8'h20, 32'h4, "R4 steer readback");
    rd_check(8'h00, 32'h2, "R4 pin0 keeps src1");
    rd_check(8'h04, 32'h4, "R4 pin1 takes src2");
    check("R4 pin1 high", {31'b0, irq1}, 32'h1);

    wr_reg(8'h38, 32'h2);
    rd_check(8'h38, 32'h0, "R3 clear-port reads zero");
    rd_check(8'h34, 32'h8000001D, "R3 bit cleared");
    idle(1);
    check("R3 pin0 drops", {31'b0, irq0}, 32'h0);

    wr_reg(8'h00, 32'hFFFF_FFFF);
    wr_reg(8'h30, 32'hFFFF_FFFF);
    wr_reg(8'h10, 32'hFFFF_FFFF);
    rd_check(8'h30, 32'h6, "R9 raw unaffected");
    rd_check(8'h34, 32'h8000001D, "R9 mask unaffected");
    rd_check(8'h10, 32'h0, "R9 undefined reads zero");

    wr_reg(8'h38, 32'h8000_0000);
    idle(1);
    check("R6 pins off", {30'b0, irq1, irq0}, 32'h0);
    rd_check(8'h04, 32'h0, "R6 pending gated");
    rd_check(8'h34, 32'h0000001D, "R6 other bits kept");
    wr_reg(8'h34, 32'h8000_0000);

    irq_src = 32'h0; wr_reg(8'h20, 32'h0);
    idle(4);
    check("R7 pin0 idle", {31'b0, irq0}, 32'h0);
    irq_src = 32'h1;
    idle(2);
    check("R8 no early rise", {31'b0, irq0}, 32'h0);
    idle(1);
    check("R7 rise on third edge", {31'b0, irq0}, 32'h1);

    wr_reg(8'h38, 32'hFFFF_FFFF);
    rd_check(8'h34, 32'h0, "R3 clear all");
    idle(3);
    check("R10 rdata held", rdata, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule